// File: doc/BRIEF.md
# Quad DAC Parallel Bus Sequencer

This block is a synchronous host-side master for a four-channel, 12-bit parallel-input DAC. A requester hands it one operation at a time over a valid/ready handshake. The four operations are: write one channel with immediate update, write all four channels and then update them together, read one channel back, and clear. The block turns each operation into the chip-select, read/write, address, data, load and clear waveforms on the DAC bus.

Every analogue timing minimum is a nanosecond parameter. Each one is converted to a whole number of system clock cycles. A read holds chip select low long enough to meet both the minimum read pulse and the data access time. The returned word is sampled on the last cycle of that pulse and handed back with a one-cycle response strobe. A turnaround gap then gives the DAC time to release the shared bus.

Top module: `dacbus_seq`

## Requirements
- R1: `req_ready` is high only when the block is idle, with chip select, load and clear all high and the data bus not driven. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. While a sequence runs, `req_valid` has no effect.
- R2: Each timing minimum becomes max(1, ceil(ns / CLK_NS)) cycles. With the defaults (CLK_NS = 4) the widths are: write chip-select pulse 3, load setup/hold 2, load pulse 3, clear pulse 3, release 4, read pulse max(8, 9) = 9.
- R3: Op code 0 (single-buffer write) runs in three parts, with load low and read/write low throughout, address `req_addr` and data `req_data[11:0]` driven throughout. First chip select stays high for the setup cycles. Then chip select is low for the write-pulse cycles. Then chip select is high again for the hold cycles. The block then returns to idle.
- R4: Op code 1 (double-buffer write) writes channels 0, 1, 2, 3 in that order with load high. Each write is one setup cycle, then chip select low for the write-pulse cycles, then one hold cycle. Then, with chip select high and the bus released, load goes low for the load-pulse cycles.
- R5: Op code 2 (read) spends one cycle with the address out, read/write high and the bus released. Chip select then goes low for the read-pulse cycles. `bus_din` is sampled on the last of those cycles.
- R6: After a read, chip select stays high for the release cycles before idle. `rsp_valid` is high for exactly the first of those cycles, and `rsp_data` holds the sampled word.
- R7: Op code 3 (clear) drives `bus_clr_n` low for the clear-pulse cycles. Chip select and load stay high and the bus is not driven.
- R8: `bus_oe` is high only during write phases. `bus_rw` is low only during write phases. Outside write and read phases, `bus_addr` is 0. `bus_dout` is 0 whenever `bus_oe` is low.
- R9: For op code 1, channel i takes its data from `req_data[12*i+11 : 12*i]` and is addressed as i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 single write, 1 write all and load, 2 read, 3 clear |
| req_addr | input | 2 | Channel for single write or read |
| req_data | input | 48 | Four 12-bit slots; slot 0 for single write |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_data | output | 12 | Last word read back |
| bus_cs_n | output | 1 | DAC chip select, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_addr | output | 2 | DAC channel address |
| bus_dout | output | 12 | Write data toward DAC |
| bus_oe | output | 1 | Output enable for the data bus driver |
| bus_din | input | 12 | Data returned by the DAC |
| bus_ldac_n | output | 1 | Load strobe, active low |
| bus_clr_n | output | 1 | Clear strobe, active low |

## Verification
The checker watches every cycle for the following: chip-select low widths, which differ for reads and writes; load and clear pulse widths; the bus driver never being enabled while read/write signals a read, and being released the cycle before a read starts; write address and data staying stable under chip select; the response strobe lasting one cycle; and ready being raised only with all strobes inactive. Only the bench's scenarios can show the exact order of the four double-buffered writes and their data slots, the sampling moment of a read against a DAC model whose data turns valid late, and that a request held through a busy sequence is taken exactly once.

// File: rtl/dacbus_seq.sv
module dacbus_seq #(
  parameter int DW       = 12,
  parameter int NCH      = 4,
  parameter int CLK_NS   = 4,
  parameter int T_WCS_NS = 10,
  parameter int T_RCS_NS = 30,
  parameter int T_ACC_NS = 35,
  parameter int T_LSU_NS = 5,
  parameter int T_LDW_NS = 10,
  parameter int T_CLR_NS = 10,
  parameter int T_REL_NS = 15,
  localparam int AW      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [NCH*DW-1:0] req_data,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              bus_cs_n,
  output logic              bus_rw,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_oe,
  input  logic [DW-1:0]     bus_din,
  output logic              bus_ldac_n,
  output logic              bus_clr_n
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int CW    = 16;
  localparam int WCS_C = cyc(T_WCS_NS);
  localparam int LSU_C = cyc(T_LSU_NS);
  localparam int LDW_C = cyc(T_LDW_NS);
  localparam int CLR_C = cyc(T_CLR_NS);
  localparam int REL_C = cyc(T_REL_NS);
  localparam int RD_C  = (cyc(T_RCS_NS) > cyc(T_ACC_NS)) ? cyc(T_RCS_NS) : cyc(T_ACC_NS);

  typedef enum logic [3:0] {
    S_IDLE, S_WPRE, S_WCS, S_WPOST, S_LOAD, S_RPRE, S_RCS, S_RREL, S_CLR
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    ch;
  logic             all_m;
  logic [NCH*DW-1:0] dbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ch        <= '0;
      all_m     <= 1'b0;
      dbuf      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          dbuf  <= req_data;
          ch    <= req_addr;
          all_m <= 1'b0;
          case (req_op)
            2'd0: begin st <= S_WPRE; cnt <= CW'(LSU_C - 1); end
            2'd1: begin st <= S_WPRE; cnt <= '0; all_m <= 1'b1; ch <= '0; end
            2'd2: begin st <= S_RPRE; cnt <= '0; end
            default: begin st <= S_CLR; cnt <= CW'(CLR_C - 1); end
          endcase
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_WPRE: begin st <= S_WCS; cnt <= CW'(WCS_C - 1); end
          S_WCS:  begin st <= S_WPOST; cnt <= all_m ? '0 : CW'(LSU_C - 1); end
          S_WPOST: begin
            if (!all_m) st <= S_IDLE;
            else if (ch == AW'(NCH - 1)) begin st <= S_LOAD; cnt <= CW'(LDW_C - 1); end
            else begin ch <= ch + 1'b1; st <= S_WPRE; cnt <= '0; end
          end
          S_RPRE: begin st <= S_RCS; cnt <= CW'(RD_C - 1); end
          S_RCS: begin
            rsp_data  <= bus_din;
            rsp_valid <= 1'b1;
            st        <= S_RREL;
            cnt       <= CW'(REL_C - 1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic          wr_ph, rd_ph;
  logic [AW-1:0] sel;

  assign wr_ph      = (st == S_WPRE) || (st == S_WCS) || (st == S_WPOST);
  assign rd_ph      = (st == S_RPRE) || (st == S_RCS) || (st == S_RREL);
  assign sel        = all_m ? ch : '0;
  assign req_ready  = (st == S_IDLE);
  assign bus_cs_n   = !((st == S_WCS) || (st == S_RCS));
  assign bus_rw     = !wr_ph;
  assign bus_oe     = wr_ph;
  assign bus_addr   = (wr_ph || rd_ph) ? ch : '0;
  assign bus_dout   = wr_ph ? dbuf[int'(sel)*DW +: DW] : '0;
  assign bus_ldac_n = !((wr_ph && !all_m) || (st == S_LOAD));
  assign bus_clr_n  = (st != S_CLR);
endmodule

// File: rtl/dacbus_seq_chk.sv
module dacbus_seq_chk #(
  parameter int DW    = 12,
  parameter int AW    = 2,
  parameter int WCS_C = 3,
  parameter int RD_C  = 9,
  parameter int LDW_C = 3,
  parameter int CLR_C = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          bus_cs_n,
  input logic          bus_rw,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          bus_oe,
  input logic          bus_ldac_n,
  input logic          bus_clr_n
);
  logic [15:0] cs_lo, ld_lo, clr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_lo <= '0; ld_lo <= '0; clr_lo <= '0;
    end else begin
      cs_lo  <= bus_cs_n   ? '0 : cs_lo + 1'b1;
      ld_lo  <= bus_ldac_n ? '0 : ld_lo + 1'b1;
      clr_lo <= bus_clr_n  ? '0 : clr_lo + 1'b1;
    end
  end

  assert_wr_cs_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_cs_n) && !$past(bus_rw)) |-> (int'(cs_lo) >= WCS_C));

  assert_rd_cs_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_cs_n) && $past(bus_rw)) |-> (int'(cs_lo) >= RD_C));

  assert_load_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_ldac_n) && $past(bus_rw)) |-> (int'(ld_lo) >= LDW_C));

  assert_clr_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clr_n) |-> (int'(clr_lo) >= CLR_C));

  assert_clr_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clr_n |-> (bus_cs_n && bus_ldac_n && !bus_oe));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_rw);

  assert_release_before_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_cs_n) && bus_rw) |-> !$past(bus_oe));

  assert_wr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !bus_rw && $past(!bus_cs_n)) |-> ($stable(bus_dout) && $stable(bus_addr)));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_ldac_n && bus_clr_n && !bus_oe));
endmodule

bind dacbus_seq dacbus_seq_chk #(
  .DW(DW), .AW(AW), .WCS_C(WCS_C), .RD_C(RD_C), .LDW_C(LDW_C), .CLR_C(CLR_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_dout(bus_dout),
  .bus_oe(bus_oe), .bus_ldac_n(bus_ldac_n), .bus_clr_n(bus_clr_n)
);

// File: tb/dacbus_seq_bench.sv
`timescale 1ns/1ps
module dacbus_seq_bench;
  localparam int CLK_NS = 4;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int W_C = cyc(10);
  localparam int S_C = cyc(5);
  localparam int L_C = cyc(10);
  localparam int C_C = cyc(10);
  localparam int Z_C = cyc(15);
  localparam int R_C = (cyc(30) > cyc(35)) ? cyc(30) : cyc(35);

  typedef struct packed {
    logic cs_n; logic rw; logic [1:0] addr; logic oe;
    logic [11:0] dout; logic ldac_n; logic clr_n; logic rv;
  } vec_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, rsp_valid;
  logic [1:0]  req_op, req_addr, bus_addr;
  logic [47:0] req_data;
  logic [11:0] rsp_data, bus_dout, bus_din;
  logic        bus_cs_n, bus_rw, bus_oe, bus_ldac_n, bus_clr_n;

  dacbus_seq u_dacbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_cs_n(bus_cs_n),
    .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .bus_ldac_n(bus_ldac_n), .bus_clr_n(bus_clr_n)
  );

  int tests = 0, fails = 0;
  logic [11:0] dev_seed = 12'h5A0;
  logic [7:0]  rd_cnt = '0;

  function automatic logic [11:0] dev_val(input logic [1:0] a);
    return dev_seed + 12'h111 * {10'd0, a};
  endfunction

  always @(posedge clk) rd_cnt <= (!bus_cs_n && bus_rw) ? rd_cnt + 8'd1 : 8'd0;
  assign bus_din = (!bus_cs_n && bus_rw && int'(rd_cnt) >= R_C - 1) ? dev_val(bus_addr) : 12'hBAD;

  function automatic vec_t mk(input logic cs, input logic rw, input logic [1:0] a, input logic oe,
                              input logic [11:0] d, input logic ld, input logic cl, input logic rv);
    vec_t v;
    v.cs_n = cs; v.rw = rw; v.addr = a; v.oe = oe; v.dout = d;
    v.ldac_n = ld; v.clr_n = cl; v.rv = rv;
    return v;
  endfunction

  vec_t  exp_q[$];
  string tag_q[$];
  logic [11:0] exp_rsp = '0;

  task automatic push(input vec_t v, input string t, input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  task automatic build(input logic [1:0] op, input logic [1:0] a, input logic [47:0] d);
    case (op)
      2'd0: begin
        push(mk(1, 0, a, 1, d[11:0], 0, 1, 0), "R3", S_C);
        push(mk(0, 0, a, 1, d[11:0], 0, 1, 0), "R2", W_C);
        push(mk(1, 0, a, 1, d[11:0], 0, 1, 0), "R3", S_C);
      end
      2'd1: begin
        for (int i = 0; i < 4; i++) begin
          push(mk(1, 0, 2'(i), 1, d[i*12 +: 12], 1, 1, 0), "R4", 1);
          push(mk(0, 0, 2'(i), 1, d[i*12 +: 12], 1, 1, 0), "R9", W_C);
          push(mk(1, 0, 2'(i), 1, d[i*12 +: 12], 1, 1, 0), "R4", 1);
        end
        push(mk(1, 1, 0, 0, 0, 0, 1, 0), "R4", L_C);
      end
      2'd2: begin
        push(mk(1, 1, a, 0, 0, 1, 1, 0), "R5", 1);
        push(mk(0, 1, a, 0, 0, 1, 1, 0), "R5", R_C);
        push(mk(1, 1, a, 0, 0, 1, 1, 1), "R6", 1);
        push(mk(1, 1, a, 0, 0, 1, 1, 0), "R6", Z_C - 1);
        exp_rsp = dev_val(a);
      end
      default: push(mk(1, 1, 0, 0, 0, 1, 0, 0), "R7", C_C);
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete(); tag_q.delete();
    end else if (exp_q.size() > 0) begin
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end else if (req_valid) begin
      build(req_op, req_addr, req_data);
    end
  end

  task automatic check(input string t, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      vec_t cur, e;
      string t;
      cur = mk(bus_cs_n, bus_rw, bus_addr, bus_oe, bus_dout, bus_ldac_n, bus_clr_n, rsp_valid);
      if (exp_q.size() > 0) begin e = exp_q[0]; t = tag_q[0]; end
      else begin e = mk(1, 1, 0, 0, 0, 1, 1, 0); t = "R8"; end
      check(t, 64'(cur), 64'(e));
      check("R1", 64'(req_ready), 64'(exp_q.size() == 0));
      if (e.rv) check("R6", 64'(rsp_data), 64'(exp_rsp));
    end
  end

  task automatic send(input logic [1:0] op, input logic [1:0] a, input logic [47:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    check("R8", 64'({bus_cs_n, bus_rw, bus_oe, bus_ldac_n, bus_clr_n, rsp_valid, req_ready}),
          64'(7'b1101101));
    rst_n = 1'b1;
    send(2'd0, 2'd2, 48'hA5C);
    send(2'd0, 2'd0, 48'hFFF);
    send(2'd1, 2'd3, {12'h444, 12'h333, 12'h222, 12'h111});
    wait_idle();
    dev_seed = 12'h5A0;
    send(2'd2, 2'd1, 48'h0);
    wait_idle();
    dev_seed = 12'h0C3;
    send(2'd2, 2'd3, 48'h0);
    send(2'd3, 2'd0, 48'h0);
    send(2'd0, 2'd3, 48'h800);
    send(2'd1, 2'd0, {12'hFFF, 12'h000, 12'h7FF, 12'h800});
    wait_idle();
    dev_seed = 12'h7F0;
    send(2'd2, 2'd0, 48'h0);
    send(2'd0, 2'd1, 48'h123);
    send(2'd3, 2'd2, 48'hFFF);
    wait_idle();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule